// File: doc/BRIEF.md
# Sequential NAND Circuit Evaluator

This block is a small programmable engine that runs a straight-line circuit built only from two-input NAND gates. The circuit is held as a list of gate entries in an internal program store. Each entry names up to two operand slots in a value file. At a start pulse the engine copies the input vector into the lowest value slots. It then executes one gate entry per clock, always in stored order. Each entry writes the NAND of its two operand values into its own slot, directly above the input slots.

After the last gate, the engine collects the top `N_OUT` value slots into a registered result and pulses done. Software, or a neighbouring block, writes the gate list through a simple write port and gives the gate count at start time. The engine trusts the loaded program: it does not check that operands refer only to earlier slots.

Top module: `nand_eval_top`

## Requirements
- R1: After reset, busy, done and result are all 0.
- R2: On an accepted start, in_bits is copied into value slots 0..N_IN-1. No gate entry ever overwrites those slots, so in_bits changes after the start do not affect that run.
- R3: Gate entry k (k counting from 0) writes NAND(a, b) into value slot N_IN+k. The entry is {a_valid, a_index, b_valid, b_index}, with a_valid at the most significant bit, a_index in the next IW bits, b_valid next and b_index in the lowest IW bits. IW = clog2(N_IN+S_MAX), which is 4 for the default parameters.
- R4: An operand whose valid bit is 0 reads as constant 0. A gate with one or both operands missing therefore produces 1.
- R5: Entries run strictly in stored order, one per clock. Every result is visible to all later entries in the same run.
- R6: result[j] equals value slot N_IN+s-N_OUT+j for j = 0..N_OUT-1, where s is the gate count latched at start.
- R7: done is a single-cycle pulse. It appears s+1 clocks after the edge that accepts start, and busy is 1 from that edge until done rises.
- R8: A start seen while busy is 1 is ignored. The run in progress keeps its inputs, its gate count and its timing, and no extra done pulse appears.
- R9: With a gate count of 0, done pulses on the cycle after start, and the result is read straight from the input slots.
- R10: result changes only on the cycle done is high and otherwise holds its value.
- R11: A start presented in the cycle where done is high is accepted and begins a new run.
- R12: The four-gate XOR program (t=NAND(x0,x1); u=NAND(x0,t); v=NAND(x1,t); y=NAND(u,v)) gives x0 XOR x1 in its last slot for all four input pairs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Write strobe for the gate list |
| ld_addr | input | AW | Gate entry index being written |
| ld_data | input | EW | Gate entry contents |
| in_bits | input | N_IN | Circuit input vector, sampled at start |
| gate_cnt | input | CW | Number of gates to run, sampled at start |
| start | input | 1 | Begin a run when idle |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | N_OUT | Registered circuit outputs |

## Verification
Two events can meet in a single cycle. The first is completion, where done pulses and result is updated. The second is acceptance of the next start. The bench provokes this by raising start on the very cycle it observes done. It then checks that the first result is correct and that the second run delivers its own result exactly gate-count-plus-one clocks after that edge. A second overlap is a start pulse with different inputs placed in the middle of a run. The scoreboard judges it by the absence of any extra done pulse and by the unchanged result of the run already under way.

// File: rtl/nand_eval_pkg.sv
package nand_eval_pkg;
   typedef enum logic [1:0] {
      EV_IDLE = 2'd0,
      EV_RUN  = 2'd1,
      EV_FIN  = 2'd2
   } ev_state_e;
endpackage

// File: rtl/nand_eval_prog_mem.sv
module nand_eval_prog_mem #(
   parameter int DEPTH = 12,
   parameter int EW    = 10,
   parameter int AW    = 4
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [EW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [EW-1:0] rdata
);
   localparam logic [AW:0] DEPTH_W = DEPTH[AW:0];

   logic [EW-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (we && ({1'b0, waddr} < DEPTH_W)) begin
         mem_q[waddr] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if ({1'b0, raddr} < DEPTH_W) begin
         rdata = mem_q[raddr];
      end
   end
endmodule

// File: rtl/nand_eval_val_store.sv
module nand_eval_val_store #(
   parameter int N_IN  = 4,
   parameter int SLOTS = 16,
   parameter int IW    = 4,
   parameter int RD_PORTS = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cap_en,
   input  logic [N_IN-1:0]              cap_bits,
   input  logic                         wr_en,
   input  logic [IW-1:0]                wr_idx,
   input  logic                         wr_bit,
   input  logic [RD_PORTS-1:0][IW-1:0]  rd_idx,
   output logic [RD_PORTS-1:0]          rd_bit,
   output logic [SLOTS-1:0]             vals
);
   localparam logic [IW:0] SLOTS_W = SLOTS[IW:0];
   localparam logic [IW:0] N_IN_W  = N_IN[IW:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vals <= '0;
      end else begin
         if (cap_en) begin
            vals[N_IN-1:0] <= cap_bits;
         end
         if (wr_en && ({1'b0, wr_idx} < SLOTS_W) && ({1'b0, wr_idx} >= N_IN_W)) begin
            vals[wr_idx] <= wr_bit;
         end
      end
   end

   for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
      always_comb begin
         rd_bit[p] = 1'b0;
         if ({1'b0, rd_idx[p]} < SLOTS_W) begin
            rd_bit[p] = vals[rd_idx[p]];
         end
      end
   end

   // R2: input slots move only when a start captures them
   p_inputs_kept_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(vals[N_IN-1:0]));

   // R3: gate writes always target a slot above the inputs
   p_gate_slot_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ({1'b0, wr_idx} >= N_IN_W));
endmodule

// File: rtl/nand_eval_seq.sv
module nand_eval_seq
   import nand_eval_pkg::*;
#(
   parameter int S_MAX = 12,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [CW-1:0] gate_cnt,
   output logic          busy,
   output logic          cap_en,
   output logic          gate_we,
   output logic          fin,
   output logic [CW-1:0] pc,
   output logic [CW-1:0] cnt
);
   localparam logic [CW-1:0] S_MAX_C = CW'(S_MAX);

   ev_state_e     st_q;
   logic [CW-1:0] cnt_eff;

   assign cnt_eff = (gate_cnt > S_MAX_C) ? S_MAX_C : gate_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= EV_IDLE;
         pc   <= '0;
         cnt  <= '0;
      end else begin
         unique case (st_q)
            EV_IDLE: begin
               if (start) begin
                  cnt  <= cnt_eff;
                  pc   <= '0;
                  st_q <= (cnt_eff == '0) ? EV_FIN : EV_RUN;
               end
            end
            EV_RUN: begin
               if (pc == cnt - 1'b1) begin
                  st_q <= EV_FIN;
               end else begin
                  pc <= pc + 1'b1;
               end
            end
            EV_FIN:  st_q <= EV_IDLE;
            default: st_q <= EV_IDLE;
         endcase
      end
   end

   assign busy    = (st_q != EV_IDLE);
   assign cap_en  = (st_q == EV_IDLE) && start;
   assign gate_we = (st_q == EV_RUN);
   assign fin     = (st_q == EV_FIN);

   // R8: a start during a run never reloads the gate count
   p_start_ignored_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cnt));

   // R5: gate pointer advances by exactly one per step inside a run
   p_pc_step_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (gate_we && (pc != cnt - 1'b1)) |=> (gate_we && pc == $past(pc) + 1'b1));
endmodule

// File: rtl/nand_eval_gather.sv
module nand_eval_gather #(
   parameter int N_IN  = 4,
   parameter int N_OUT = 2,
   parameter int SLOTS = 16,
   parameter int IW    = 4,
   parameter int CW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fin,
   input  logic [CW-1:0]    cnt,
   input  logic [SLOTS-1:0] vals,
   output logic [N_OUT-1:0] result,
   output logic             done
);
   localparam logic [IW:0] SLOTS_W = SLOTS[IW:0];

   logic [IW:0]      base;
   logic [N_OUT-1:0] picked;

   assign base = (IW+1)'(N_IN) + (IW+1)'(cnt) - (IW+1)'(N_OUT);

   for (genvar j = 0; j < N_OUT; j++) begin : g_out
      logic [IW:0] idx;
      assign idx = base + (IW+1)'(j);
      always_comb begin
         picked[j] = 1'b0;
         if (idx < SLOTS_W) begin
            picked[j] = vals[idx[IW-1:0]];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result <= '0;
         done   <= 1'b0;
      end else begin
         done <= fin;
         if (fin) begin
            result <= picked;
         end
      end
   end

   // R10: result only moves together with done
   p_result_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   // R7: done lasts exactly one cycle
   p_done_single_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: rtl/nand_eval_top.sv
module nand_eval_top #(
   parameter int N_IN  = 4,
   parameter int N_OUT = 2,
   parameter int S_MAX = 12,
   localparam int SLOTS = N_IN + S_MAX,
   localparam int IW    = $clog2(SLOTS),
   localparam int EW    = 2 * IW + 2,
   localparam int AW    = $clog2(S_MAX),
   localparam int CW    = $clog2(S_MAX + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [AW-1:0]    ld_addr,
   input  logic [EW-1:0]    ld_data,
   input  logic [N_IN-1:0]  in_bits,
   input  logic [CW-1:0]    gate_cnt,
   input  logic             start,
   output logic             busy,
   output logic             done,
   output logic [N_OUT-1:0] result
);
   if (N_IN < 1) begin : g_bad_n
      $error("nand_eval_top: N_IN must be at least 1");
   end
   if (S_MAX < 2) begin : g_bad_s
      $error("nand_eval_top: S_MAX must be at least 2");
   end
   if (N_OUT < 1 || N_OUT > SLOTS) begin : g_bad_m
      $error("nand_eval_top: N_OUT must lie in 1..N_IN+S_MAX");
   end

   logic                cap_en, gate_we, fin;
   logic [CW-1:0]       pc, cnt;
   logic [EW-1:0]       entry;
   logic [1:0][IW-1:0]  rd_idx;
   logic [1:0]          rd_bit;
   logic [1:0]          op_ok;
   logic [1:0]          op_val;
   logic [IW-1:0]       wr_idx;
   logic                wr_bit;
   logic [SLOTS-1:0]    vals;

   nand_eval_seq #(.S_MAX(S_MAX), .CW(CW)) seq_i (
      .clk(clk), .rst_n(rst_n), .start(start), .gate_cnt(gate_cnt),
      .busy(busy), .cap_en(cap_en), .gate_we(gate_we), .fin(fin),
      .pc(pc), .cnt(cnt)
   );

   nand_eval_prog_mem #(.DEPTH(S_MAX), .EW(EW), .AW(AW)) prog_i (
      .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_data),
      .raddr(pc[AW-1:0]), .rdata(entry)
   );

   // Operand decode: {a_valid, a_index, b_valid, b_index}
   assign op_ok[0]  = entry[EW-1];
   assign rd_idx[0] = entry[EW-2 -: IW];
   assign op_ok[1]  = entry[IW];
   assign rd_idx[1] = entry[IW-1:0];

   for (genvar p = 0; p < 2; p++) begin : g_op
      assign op_val[p] = op_ok[p] & rd_bit[p];
   end

   assign wr_bit = ~(op_val[0] & op_val[1]);
   assign wr_idx = IW'(N_IN) + IW'(pc);

   nand_eval_val_store #(.N_IN(N_IN), .SLOTS(SLOTS), .IW(IW), .RD_PORTS(2)) vals_i (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_bits(in_bits),
      .wr_en(gate_we), .wr_idx(wr_idx), .wr_bit(wr_bit),
      .rd_idx(rd_idx), .rd_bit(rd_bit), .vals(vals)
   );

   nand_eval_gather #(.N_IN(N_IN), .N_OUT(N_OUT), .SLOTS(SLOTS), .IW(IW), .CW(CW)) gath_i (
      .clk(clk), .rst_n(rst_n), .fin(fin), .cnt(cnt), .vals(vals),
      .result(result), .done(done)
   );

   // R7: completion is never reported while still busy
   p_done_idle_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R4: a gate with a missing operand always writes 1
   p_missing_one_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (gate_we && !(op_ok[0] && op_ok[1])) |-> wr_bit);
endmodule

// File: tb/nand_eval_top_tb_top.sv
module nand_eval_top_tb_top;
   localparam int N_IN  = 4;
   localparam int N_OUT = 2;
   localparam int S_MAX = 12;
   localparam int SLOTS = N_IN + S_MAX;
   localparam int IW    = $clog2(SLOTS);
   localparam int EW    = 2 * IW + 2;
   localparam int AW    = $clog2(S_MAX);
   localparam int CW    = $clog2(S_MAX + 1);

   typedef struct {
      logic [N_OUT-1:0] exp_res;
      int               exp_cyc;
      string            req;
   } sb_item_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ld_en = 1'b0;
   logic [AW-1:0]    ld_addr = '0;
   logic [EW-1:0]    ld_data = '0;
   logic [N_IN-1:0]  in_bits = '0;
   logic [CW-1:0]    gate_cnt = '0;
   logic             start = 1'b0;
   logic             busy, done;
   logic [N_OUT-1:0] result;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 0;
   sb_item_t sbq[$];
   logic [EW-1:0] prog [S_MAX];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   nand_eval_top #(.N_IN(N_IN), .N_OUT(N_OUT), .S_MAX(S_MAX)) dut_i (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .in_bits(in_bits), .gate_cnt(gate_cnt), .start(start),
      .busy(busy), .done(done), .result(result)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [EW-1:0] ent(input bit av, input int ai, input bit bv, input int bi);
      return {av, IW'(ai), bv, IW'(bi)};
   endfunction

   // Reference interpreter written from R3..R6
   function automatic logic [N_OUT-1:0] model(input logic [N_IN-1:0] x, input int s);
      logic [SLOTS-1:0] v;
      logic [N_OUT-1:0] y;
      logic a, b;
      v = '0;
      for (int i = 0; i < N_IN; i++) v[i] = x[i];
      for (int k = 0; k < s; k++) begin
         a = prog[k][EW-1] ? v[prog[k][EW-2 -: IW]] : 1'b0;
         b = prog[k][IW]   ? v[prog[k][IW-1:0]]     : 1'b0;
         v[N_IN+k] = ~(a & b);
      end
      for (int j = 0; j < N_OUT; j++) y[j] = v[N_IN+s-N_OUT+j];
      return y;
   endfunction

   task automatic load_prog(input int s);
      for (int k = 0; k < s; k++) begin
         @(negedge clk);
         ld_en = 1'b1; ld_addr = AW'(k); ld_data = prog[k];
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   // Driver: call at a negedge; drives a one-cycle start and pushes the expectation
   task automatic drive_start(input logic [N_IN-1:0] x, input int s, input string req);
      sb_item_t it;
      in_bits = x; gate_cnt = CW'(s); start = 1'b1;
      it.exp_res = model(x, s);
      it.exp_cyc = cyc + 1 + s + 1;
      it.req = req;
      sbq.push_back(it);
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy || sbq.size() != 0) @(negedge clk);
   endtask

   // Monitor: compares every done pulse against the queue head
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sbq.size() == 0) begin
            check(1'b0, "R8 unexpected done", 1, 0);
         end else begin
            sb_item_t it;
            it = sbq.pop_front();
            check(result == it.exp_res, {it.req, " result"}, int'(result), int'(it.exp_res));
            check(cyc == it.exp_cyc, {"R7 done timing / ", it.req}, cyc, it.exp_cyc);
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(busy == 1'b0, "R1 busy", int'(busy), 0);
      check(done == 1'b0, "R1 done", int'(done), 0);
      check(result == '0, "R1 result", int'(result), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 / R3 / R5: XOR program, four gates
      prog[0] = ent(1, 0, 1, 1);
      prog[1] = ent(1, 0, 1, 4);
      prog[2] = ent(1, 1, 1, 4);
      prog[3] = ent(1, 5, 1, 6);
      load_prog(4);
      for (int p = 0; p < 4; p++) begin
         logic [N_IN-1:0] x;
         x = N_IN'(p);
         @(negedge clk);
         drive_start(x, 4, "R12 xor");
         wait_idle();
         check(result[1] == (x[0] ^ x[1]), "R12 xor bit", int'(result[1]), int'(x[0] ^ x[1]));
      end

      // R8: a start during the run with other inputs is ignored
      @(negedge clk);
      drive_start(4'b0001, 4, "R8 first run kept");
      in_bits = 4'b0011; start = 1'b1;
      check(busy == 1'b1, "R7 busy during run", int'(busy), 1);
      @(negedge clk);
      start = 1'b0;
      in_bits = 4'b0000;  // R2: late input change has no effect
      wait_idle();
      repeat (3) @(negedge clk);

      // R10: result holds while idle and inputs move
      begin
         logic [N_OUT-1:0] held;
         held = result;
         in_bits = 4'b1111;
         repeat (4) @(negedge clk);
         check(result == held, "R10 hold", int'(result), int'(held));
      end

      // R4: missing operands read as zero
      prog[0] = ent(1, 0, 0, 0);
      prog[1] = ent(0, 0, 0, 0);
      prog[2] = ent(1, 4, 1, 5);
      load_prog(3);
      @(negedge clk);
      drive_start(4'b1111, 3, "R4 missing operand");
      wait_idle();
      check(result == 2'b01, "R4 explicit", int'(result), 1);

      // R9 / R6: zero gates, outputs from input slots 2..3
      @(negedge clk);
      drive_start(4'b1000, 0, "R9 zero gates");
      check(busy == 1'b1, "R9 busy one cycle", int'(busy), 1);
      wait_idle();
      check(result == 2'b10, "R9 explicit", int'(result), 2);

      // R5 / R6: full-length chain, each gate uses the previous result
      for (int k = 0; k < S_MAX; k++) begin
         if (k == 0) prog[k] = ent(1, 0, 1, 1);
         else        prog[k] = ent(1, N_IN + k - 1, 1, (k * 3) % (N_IN + k));
      end
      load_prog(S_MAX);
      for (int p = 0; p < 6; p++) begin
         @(negedge clk);
         drive_start(N_IN'(p * 5 + 1), S_MAX, "R5 chain");
         wait_idle();
      end

      // R11: start presented in the done cycle is accepted
      @(negedge clk);
      drive_start(4'b0110, 5, "R11 first");
      while (!done) @(negedge clk);
      drive_start(4'b1001, 7, "R11 second");
      wait_idle();

      // R6: shorter prefix of the same program, other output slots
      @(negedge clk);
      drive_start(4'b1010, 2, "R6 short program");
      wait_idle();

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule